// File: doc/BRIEF.md
# Exception Priority Mask and Core Control Registers

This unit holds two special registers of a small processor core: a base-priority mask and a three-bit core-control word. The mask gates exception activation. Each pending request presents an 8-bit priority value, where a larger number means a less urgent exception. The unit returns one "may activate" flag per request. A mask of zero lets every request through. A nonzero mask blocks every request whose value is at or above it.

The control word holds three settings:

- the thread-mode privilege level,
- the stack-pointer selection (main or process),
- a flag that marks a live floating-point context.

Software reads and writes both registers through a single-cycle register port. Writes take effect only while the core is privileged. The core is privileged in handler mode, or in thread mode with the privilege bit clear.

In handler mode the main stack is always in use. The stack-select bit therefore reads as zero and ignores explicit writes in that mode. On exception return, a dedicated update port reloads the stack-select bit and the floating-point flag. Inside the control path, the privilege and stack bits form an enumerated four-state machine:

| State | Privilege | Stack |
|---|---|---|
| CTX_PRIV_MAIN | privileged | main |
| CTX_UNPRIV_MAIN | unprivileged | main |
| CTX_PRIV_PROC | privileged | process |
| CTX_UNPRIV_PROC | unprivileged | process |

The named transitions of this machine are:

- **privilege drop**: an accepted write with bit 0 set.
- **privilege restore**: an accepted write with bit 0 clear. From an unprivileged state this is possible only in handler mode.
- **stack switch**: a thread-mode write to bit 1, or an exception-return load.

Top module: `excm_unit`

## Requirements
- R1: After reset, the mask reads 0x00000000, the control word reads 0x00000000, all requests are allowed, and the core is privileged on the main stack with no floating-point context.
- R2: While the stored mask is zero, every bit of `req_allow` is 1, whatever the request priorities are.
- R3: While the mask is nonzero, `req_allow[i]` is 0 when the priority in `req_prio[8i+7:8i]` is greater than or equal to the 8-bit mask value, and 1 otherwise.
- R4: Mask reads (`acc_sel`=0) return the mask in bits [7:0] with bits [31:8] zero. Only the top `PRIO_BITS` bits of [7:0] are stored; the lower ones read zero and ignore writes (default 4 bits: writing 0xFF reads 0xF0, writing 0x45 reads 0x40).
- R5: Control reads (`acc_sel`=1) return privilege in bit 0 (1 = unprivileged), stack select in bit 1 (1 = process), the floating-point context flag in bit 2, and zero in bits [31:3].
- R6: In handler mode, the stack-select bit reads 0, `sp_is_process` is 0, and an accepted write leaves the stored stack-select bit unchanged. Bits 0 and 2 are still written.
- R7: In privileged thread mode, a write to either register is applied at the next clock edge.
- R8: In thread mode with privilege bit 0 set, writes to both registers are ignored. In handler mode, writes are accepted regardless of the privilege bit.
- R9: When `exr_valid` is high, stack select is loaded from `exr_stack` and the floating-point flag from `exr_fp`. In the same cycle this takes precedence over a register write for those two bits; bit 0 of such a write still applies.
- R10: With `HAS_FPU`=0, the floating-point flag reads 0 and ignores both writes and exception-return loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| handler_mode | input | 1 | 1 while the core runs an exception handler |
| acc_wr | input | 1 | Register write strobe |
| acc_sel | input | 1 | Register select: 0 mask, 1 control |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data of the selected register (combinational) |
| exr_valid | input | 1 | Exception-return update strobe |
| exr_stack | input | 1 | Stack select to load on exception return |
| exr_fp | input | 1 | Floating-point flag to load on exception return |
| req_prio | input | 8*NUM_REQ | Priority value of each pending request |
| req_allow | output | NUM_REQ | Per-request activation permission |
| sp_is_process | output | 1 | Process stack is active |
| thread_unpriv | output | 1 | Thread mode runs unprivileged |
| fp_active | output | 1 | Floating-point context is live |

## Verification
Register writes and exception-return loads land at the first rising edge after they are presented. Read data and `req_allow` are combinational from the stored registers, so a written value becomes visible one cycle after the strobe. The mode-dependent view of stack select follows `handler_mode` within the same cycle. The driver applies every stimulus on a falling edge and queues each expected value with the edge count at which it becomes due. The monitor samples a quarter period after that rising edge, before the next stimulus is applied.

// File: rtl/excm_pkg.sv
package excm_pkg;

    localparam int unsigned PRIO_W = 8;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned CTRL_W = 3;

    localparam logic SEL_MASK = 1'b0;
    localparam logic SEL_CTRL = 1'b1;

    // encoding is {stack_select, unprivileged}
    typedef enum logic [1:0] {
        CTX_PRIV_MAIN   = 2'b00,
        CTX_UNPRIV_MAIN = 2'b01,
        CTX_PRIV_PROC   = 2'b10,
        CTX_UNPRIV_PROC = 2'b11
    } ctx_e;

endpackage

// File: rtl/excm_mask_reg.sv
module excm_mask_reg
    import excm_pkg::*;
#(
    parameter int unsigned PRIO_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PRIO_BITS-1:0] wr_field,
    output logic [PRIO_W-1:0]    mask_val
);

    localparam int unsigned LOW_ZERO = PRIO_W - PRIO_BITS;

    logic [PRIO_BITS-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q <= wr_field;
        end
    end

    always_comb begin
        mask_val = PRIO_W'(mask_q) << LOW_ZERO;
    end

endmodule

// File: rtl/excm_prio_gate.sv
module excm_prio_gate
    import excm_pkg::*;
#(
    parameter int unsigned NUM_REQ = 8
) (
    input  logic [PRIO_W-1:0]         mask_val,
    input  logic [NUM_REQ*PRIO_W-1:0] req_prio,
    output logic [NUM_REQ-1:0]        req_allow
);

    logic mask_off;

    always_comb begin
        mask_off = (mask_val == '0);
    end

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
        logic [PRIO_W-1:0] prio_g;
        always_comb begin
            prio_g       = req_prio[g*PRIO_W +: PRIO_W];
            req_allow[g] = mask_off | (prio_g < mask_val);
        end
    end

endmodule

// File: rtl/excm_ctrl_fsm.sv
module excm_ctrl_fsm
    import excm_pkg::*;
#(
    parameter bit HAS_FPU = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              handler_mode,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_bits,
    input  logic              exr_valid,
    input  logic              exr_stack,
    input  logic              exr_fp,
    output logic [CTRL_W-1:0] ctrl_bits
);

    ctx_e ctx_q;
    ctx_e ctx_d;
    logic unpriv_cur;
    logic stack_cur;
    logic unpriv_nxt;
    logic stack_nxt;
    logic fp_cur;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= CTX_PRIV_MAIN;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    // state decode
    always_comb begin
        unique case (ctx_q)
            CTX_PRIV_MAIN:   begin unpriv_cur = 1'b0; stack_cur = 1'b0; end
            CTX_UNPRIV_MAIN: begin unpriv_cur = 1'b1; stack_cur = 1'b0; end
            CTX_PRIV_PROC:   begin unpriv_cur = 1'b0; stack_cur = 1'b1; end
            CTX_UNPRIV_PROC: begin unpriv_cur = 1'b1; stack_cur = 1'b1; end
            default:         begin unpriv_cur = 1'b0; stack_cur = 1'b0; end
        endcase
    end

    // transitions: privilege drop / restore, stack switch
    always_comb begin
        unpriv_nxt = wr_en ? wr_bits[0] : unpriv_cur;
        if (exr_valid) begin
            stack_nxt = exr_stack;
        end else if (wr_en && !handler_mode) begin
            stack_nxt = wr_bits[1];
        end else begin
            stack_nxt = stack_cur;
        end
        unique case ({stack_nxt, unpriv_nxt})
            2'b00:   ctx_d = CTX_PRIV_MAIN;
            2'b01:   ctx_d = CTX_UNPRIV_MAIN;
            2'b10:   ctx_d = CTX_PRIV_PROC;
            2'b11:   ctx_d = CTX_UNPRIV_PROC;
            default: ctx_d = CTX_PRIV_MAIN;
        endcase
    end

    if (HAS_FPU) begin : g_fp
        logic fp_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fp_q <= 1'b0;
            end else if (exr_valid) begin
                fp_q <= exr_fp;
            end else if (wr_en) begin
                fp_q <= wr_bits[2];
            end
        end
        always_comb fp_cur = fp_q;
    end else begin : g_nofp
        logic [1:0] unused_fp_in;
        always_comb begin
            unused_fp_in = {wr_bits[2], exr_fp};
            fp_cur       = 1'b0;
        end
    end

    always_comb begin
        ctrl_bits = {fp_cur, stack_cur, unpriv_cur};
    end

endmodule

// File: rtl/excm_unit.sv
module excm_unit
    import excm_pkg::*;
#(
    parameter int unsigned NUM_REQ   = 8,
    parameter int unsigned PRIO_BITS = 4,
    parameter bit          HAS_FPU   = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         handler_mode,
    input  logic                         acc_wr,
    input  logic                         acc_sel,
    input  logic [31:0]                  acc_wdata,
    output logic [31:0]                  acc_rdata,
    input  logic                         exr_valid,
    input  logic                         exr_stack,
    input  logic                         exr_fp,
    input  logic [NUM_REQ*8-1:0]         req_prio,
    output logic [NUM_REQ-1:0]           req_allow,
    output logic                         sp_is_process,
    output logic                         thread_unpriv,
    output logic                         fp_active
);

    logic [PRIO_W-1:0] mask8;
    logic [CTRL_W-1:0] ctrl3;
    logic              priv_ok;
    logic              mask_wr;
    logic              ctrl_wr;
    logic [31:0]       unused_wdata;

    always_comb begin
        unused_wdata = acc_wdata;
        priv_ok      = handler_mode | ~ctrl3[0];
        mask_wr      = acc_wr & priv_ok & (acc_sel == SEL_MASK);
        ctrl_wr      = acc_wr & priv_ok & (acc_sel == SEL_CTRL);
    end

    excm_mask_reg #(.PRIO_BITS(PRIO_BITS)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mask_wr),
        .wr_field (acc_wdata[PRIO_W-1 -: PRIO_BITS]),
        .mask_val (mask8)
    );

    excm_prio_gate #(.NUM_REQ(NUM_REQ)) u_gate (
        .mask_val  (mask8),
        .req_prio  (req_prio),
        .req_allow (req_allow)
    );

    excm_ctrl_fsm #(.HAS_FPU(HAS_FPU)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .handler_mode (handler_mode),
        .wr_en        (ctrl_wr),
        .wr_bits      (acc_wdata[CTRL_W-1:0]),
        .exr_valid    (exr_valid),
        .exr_stack    (exr_stack),
        .exr_fp       (exr_fp),
        .ctrl_bits    (ctrl3)
    );

    always_comb begin
        sp_is_process = ctrl3[1] & ~handler_mode;
        thread_unpriv = ctrl3[0];
        fp_active     = ctrl3[2];
        if (acc_sel == SEL_MASK) begin
            acc_rdata = {{(REG_W-PRIO_W){1'b0}}, mask8};
        end else begin
            acc_rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl3[2], sp_is_process, ctrl3[0]};
        end
    end

endmodule

// File: rtl/excm_unit_chk.sv
module excm_unit_chk
    import excm_pkg::*;
#(
    parameter int unsigned NUM_REQ   = 8,
    parameter int unsigned PRIO_BITS = 4,
    parameter bit          HAS_FPU   = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               handler_mode,
    input logic               acc_sel,
    input logic [31:0]        acc_rdata,
    input logic               exr_valid,
    input logic               exr_stack,
    input logic [NUM_REQ-1:0] req_allow,
    input logic               sp_is_process,
    input logic               thread_unpriv,
    input logic [PRIO_W-1:0]  mask8,
    input logic [CTRL_W-1:0]  ctrl3
);

    localparam logic [31:0] KEEP = 32'((8'hFF << (PRIO_W - PRIO_BITS)) & 8'hFF);

    AST_HANDLER_MAIN_SP: assert property (@(posedge clk) disable iff (!rst_n)
        handler_mode |-> !sp_is_process); // R6

    AST_ZERO_MASK_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mask8 == '0) |-> (&req_allow)); // R2

    AST_MASK_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel == SEL_MASK) |-> ((acc_rdata & ~KEEP) == 32'd0)); // R4

    AST_UNPRIV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!handler_mode && thread_unpriv && !exr_valid) |=> ($stable(mask8) && $stable(ctrl3))); // R8

    AST_EXR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        exr_valid |=> (ctrl3[1] == $past(exr_stack))); // R9

    if (!HAS_FPU) begin : g_nofp_chk
        AST_NOFP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl3[2] == 1'b0)); // R10
    end

endmodule

bind excm_unit excm_unit_chk #(
    .NUM_REQ(NUM_REQ), .PRIO_BITS(PRIO_BITS), .HAS_FPU(HAS_FPU)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .handler_mode  (handler_mode),
    .acc_sel       (acc_sel),
    .acc_rdata     (acc_rdata),
    .exr_valid     (exr_valid),
    .exr_stack     (exr_stack),
    .req_allow     (req_allow),
    .sp_is_process (sp_is_process),
    .thread_unpriv (thread_unpriv),
    .mask8         (mask8),
    .ctrl3         (ctrl3)
);

// File: tb/excm_unit_tb_top.sv
module excm_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NREQ = 8;

    typedef struct {
        int          due;
        int          kind;   // 0 rdata, 1 allow, 2 {fp,unpriv,sp}, 3 rdata without fp
        logic [31:0] exp;
        string       tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              handler_mode = 1'b0;
    logic              acc_wr = 1'b0;
    logic              acc_sel = 1'b0;
    logic [31:0]       acc_wdata = '0;
    logic              exr_valid = 1'b0;
    logic              exr_stack = 1'b0;
    logic              exr_fp = 1'b0;
    logic [NREQ*8-1:0] req_prio = 64'h803C10FF41403F00;
    logic [31:0]       acc_rdata, rdata_nf;
    logic [NREQ-1:0]   req_allow, allow_nf;
    logic              sp_is_process, thread_unpriv, fp_active;
    logic              sp_nf, unpriv_nf, fp_nf;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    excm_unit #(.NUM_REQ(NREQ), .PRIO_BITS(4), .HAS_FPU(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .handler_mode(handler_mode),
        .acc_wr(acc_wr), .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .exr_valid(exr_valid), .exr_stack(exr_stack), .exr_fp(exr_fp),
        .req_prio(req_prio), .req_allow(req_allow),
        .sp_is_process(sp_is_process), .thread_unpriv(thread_unpriv), .fp_active(fp_active)
    );

    excm_unit #(.NUM_REQ(NREQ), .PRIO_BITS(4), .HAS_FPU(1'b0)) dut_nofp_i (
        .clk(clk), .rst_n(rst_n), .handler_mode(handler_mode),
        .acc_wr(acc_wr), .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_rdata(rdata_nf),
        .exr_valid(exr_valid), .exr_stack(exr_stack), .exr_fp(exr_fp),
        .req_prio(req_prio), .req_allow(allow_nf),
        .sp_is_process(sp_nf), .thread_unpriv(unpriv_nf), .fp_active(fp_nf)
    );

    // driver: one stimulus per falling edge
    task automatic step(input logic w, input logic s, input logic [31:0] d,
                        input logic hm, input logic ev, input logic es, input logic ef);
        @(negedge clk);
        acc_wr = w; acc_sel = s; acc_wdata = d; handler_mode = hm;
        exr_valid = ev; exr_stack = es; exr_fp = ef;
    endtask

    // expectation due after the coming rising edge
    task automatic expect_at(input int kind, input logic [31:0] exp, input string tag);
        exp_t e;
        e.due = cyc + 1; e.kind = kind; e.exp = exp; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            while (q.size() > 0 && q[0].due <= cyc) begin
                exp_t e;
                logic [31:0] act;
                e = q.pop_front();
                case (e.kind)
                    0: act = acc_rdata;
                    1: act = 32'(req_allow);
                    2: act = {29'd0, fp_active, thread_unpriv, sp_is_process};
                    default: act = rdata_nf;
                endcase
                n_chk++;
                if (act !== e.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual=%h expected=%h", e.tag, act, e.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(0, 0, 0, 0, 0, 0, 0);
        expect_at(0, 32'h0, "R1 mask after reset");
        expect_at(2, 32'h0, "R1 outputs after reset");
        expect_at(1, 32'hFF, "R2 zero mask allows all");
        step(0, 1, 0, 0, 0, 0, 0);
        expect_at(0, 32'h0, "R1 control after reset");
        // R4 unimplemented bits
        step(1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        expect_at(0, 32'hF0, "R4 write all ones");
        step(1, 0, 32'h45, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        expect_at(0, 32'h40, "R4 low bits dropped");
        expect_at(1, 32'h63, "R3 mask 0x40 gating");
        step(1, 0, 32'h3C, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        expect_at(1, 32'h21, "R3 mask 0x30 gating");
        step(1, 0, 32'h40, 0, 0, 0, 0);
        // R7 privileged thread write, R5 layout, R10 no-fpu variant
        step(1, 1, 32'h6, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0, 0);
        expect_at(0, 32'h6, "R7 R5 control write");
        expect_at(2, 32'h5, "R7 outputs process+fp");
        expect_at(3, 32'h2, "R10 fp flag absent");
        // R6 handler view and ignored stack write
        step(0, 1, 0, 1, 0, 0, 0);
        expect_at(0, 32'h4, "R6 handler reads stack zero");
        expect_at(2, 32'h4, "R6 handler main stack");
        step(1, 1, 32'h0, 1, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0, 0);
        expect_at(0, 32'h2, "R6 handler stack write ignored");
        expect_at(2, 32'h1, "R6 thread back on process");
        // R9 exception return
        step(0, 1, 0, 1, 1, 0, 1);
        step(0, 1, 0, 0, 0, 0, 0);
        expect_at(0, 32'h4, "R9 return loads stack and fp");
        expect_at(3, 32'h0, "R10 return fp ignored");
        step(1, 1, 32'h4, 1, 1, 1, 0);
        step(0, 1, 0, 0, 0, 0, 0);
        expect_at(0, 32'h2, "R9 return wins over write");
        // R8 unprivileged writes ignored
        step(1, 1, 32'h3, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0, 0);
        expect_at(0, 32'h3, "R8 drop privilege");
        expect_at(2, 32'h3, "R8 outputs unprivileged");
        step(1, 0, 32'h80, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        expect_at(0, 32'h40, "R8 mask write ignored");
        step(1, 1, 32'h0, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0, 0);
        expect_at(0, 32'h3, "R8 control write ignored");
        step(1, 1, 32'h4, 1, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0, 0);
        expect_at(0, 32'h6, "R8 handler write accepted");
        step(1, 0, 32'h0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        expect_at(0, 32'h0, "R2 mask cleared");
        expect_at(1, 32'hFF, "R2 all allowed again");
        step(0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule